// File: doc/BRIEF.md
# Conversion Sequencer with Settling Mask and Offset Calibration

This block sits beside a decimating delta-sigma converter core and owns its conversion timing. It counts master clocks per conversion period (a long period in the slow rate mode, a short one in the fast mode) and takes one filtered word from the core at the end of each period. It also watches the channel, gain and rate selection inputs. Any change to them resets the modulator and filter, and the block then holds back the valid strobe until the filter has settled for four conversion periods.

Three more duties complete it. A word that the core flags as over range is clipped to full scale and is followed by a filter restart, which cuts the output word rate to roughly a quarter. On request the block runs an offset calibration: it shorts the analog inputs, converts until the filter has settled, and stores the result. It then restarts with the inputs released, and every later word has that stored offset subtracted, with saturation. A standby input parks the converter with its filter held in reset but keeps the stored offset. The active-low reset acts as power-down and clears the offset.

Top module: `conv_sequencer`

## Requirements
- R1: While `rst_n` is low, `word_valid`, `filt_rst` and `short_in` are 0 and `word_o` is 0.
- R2: After reset release, conversions start at once. The first `word_valid` comes on the N-th rising clock edge after release, and later ones follow every N edges. N is `FAST_CYC` when `rate_fast` is 1 and `SLOW_CYC` when it is 0.
- R3: A change on `chan_sel`, `gain_sel` or `rate_fast` makes `filt_rst` high in the cycle after the edge that samples the change.
- R4: After such a change, no word is flagged until four conversion periods of the new setting have elapsed. The first `word_valid` comes on edge 4N+2, counting the sampling edge as edge 1.
- R5: A further control change while settling is in progress restarts the settling count, measured from the new change.
- R6: Each flagged word equals `raw_word` minus the stored offset, as 24-bit two's complement. After power-up the stored offset is zero.
- R7: The offset subtraction saturates to 0x7FFFFF above and 0x800000 below instead of wrapping.
- R8: When `raw_ovr` is 1 at the end of a period, the flagged word is 0x7FFFFF if bit 23 of `raw_word` is 0 and 0x800000 if it is 1, with no offset applied. The filter is then restarted, and the next word comes 4N+1 edges later.
- R9: A `cal_req` pulse sets `short_in` high from the next cycle for four periods, with no word flagged. The last shorted result becomes the stored offset. The filter then restarts unshorted, and the first word comes on edge 8N+3 counting the request edge as edge 1.
- R10: While `standby` is high, `filt_rst` stays high from the next cycle and no word is flagged. The edge that samples its release starts a restart, the first word comes on edge 4N+2, and the stored offset survives standby.
- R11: Asserting `rst_n` low clears the stored offset back to zero.
- R12: `word_valid` is a single-cycle pulse, and `word_o` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset; acts as power-down |
| standby | input | 1 | Parks the converter while high |
| chan_sel | input | CH_W | Input channel selection |
| gain_sel | input | GAIN_W | Amplifier gain selection |
| rate_fast | input | 1 | 1 = short conversion period, 0 = long |
| cal_req | input | 1 | Pulse requesting an offset calibration |
| raw_word | input | DATA_W | Filter result from the converter core |
| raw_ovr | input | 1 | Core flag: input beyond full scale |
| word_o | output | DATA_W | Corrected conversion word |
| word_valid | output | 1 | One-cycle strobe for a new word |
| filt_rst | output | 1 | Holds modulator and filter in reset |
| short_in | output | 1 | Shorts the analog inputs internally |

## Verification
The bench times every first word after a control change, a calibration, a standby release and an over-range event in clock edges. A design that miscounted the settling periods, or that did not restart the count on a second change during settling, would flag words early or late, and the bench would report the gap. Saturation is probed at both rails with positive and negative stored offsets: a design that wrapped would return a word of the opposite sign. Clipping is checked for both polarities with the offset applied, so a design that subtracted the offset from a clipped word would miss the full-scale codes. Standby and power-down are checked through the next corrected word, which shows whether the offset was kept or cleared.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_RUN         = 3'd0,
        SEQ_RESTART     = 3'd1,
        SEQ_SETTLE      = 3'd2,
        SEQ_CAL_RESTART = 3'd3,
        SEQ_CAL_SETTLE  = 3'd4,
        SEQ_STANDBY     = 3'd5
    } seq_state_e;

endpackage

// File: rtl/conv_seq_period_timer.sv
module conv_seq_period_timer #(
    parameter int unsigned SLOW_CYC = 491520,
    parameter int unsigned FAST_CYC = 61440
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic fast,
    output logic period_end
);
    localparam int unsigned MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CYC - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    assign last_val   = fast ? FAST_LAST : SLOW_LAST;
    assign period_end = run && (cnt_q >= last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            if (period_end) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/conv_seq_ctrl_watch.sv
module conv_seq_ctrl_watch #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ctrl,
    output logic         changed
);
    logic [W-1:0] ctrl_q;
    logic         primed_q;

    assign changed = primed_q && (ctrl != ctrl_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            ctrl_q   <= ctrl;
            primed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/conv_seq_offset_unit.sv
module conv_seq_offset_unit #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] raw,
    input  logic         ovr,
    output logic [W-1:0] word
);
    localparam logic [W-1:0] POS_FS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_FS = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] offset_q;
    logic [W:0]   diff;
    logic [W-1:0] sat_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q <= '0;
        end else if (load) begin
            offset_q <= raw;
        end
    end

    assign diff = {raw[W-1], raw} - {offset_q[W-1], offset_q};

    always_comb begin
        if (diff[W] != diff[W-1]) begin
            sat_word = diff[W] ? NEG_FS : POS_FS;
        end else begin
            sat_word = diff[W-1:0];
        end
    end

    always_comb begin
        if (ovr) begin
            word = raw[W-1] ? NEG_FS : POS_FS;
        end else begin
            word = sat_word;
        end
    end

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int unsigned DATA_W         = 24,
    parameter int unsigned CH_W           = 2,
    parameter int unsigned GAIN_W         = 2,
    parameter int unsigned SLOW_CYC       = 491520,
    parameter int unsigned FAST_CYC       = 61440,
    parameter int unsigned SETTLE_PERIODS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic [GAIN_W-1:0] gain_sel,
    input  logic              rate_fast,
    input  logic              cal_req,
    input  logic [DATA_W-1:0] raw_word,
    input  logic              raw_ovr,
    output logic [DATA_W-1:0] word_o,
    output logic              word_valid,
    output logic              filt_rst,
    output logic              short_in
);
    localparam int unsigned CTRL_W = CH_W + GAIN_W + 1;
    localparam int unsigned SET_W  = $clog2(SETTLE_PERIODS + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_PERIODS - 1);

    seq_state_e state_q, state_n;

    logic              ctrl_changed;
    logic              period_end;
    logic              tmr_clear;
    logic              tmr_run;
    logic [SET_W-1:0]  settle_q;
    logic              settle_last;
    logic              cal_pend_q;
    logic              cal_any;
    logic              take_cal;
    logic              emit;
    logic              store_off;
    logic [DATA_W-1:0] corr_word;

    conv_seq_ctrl_watch #(
        .W (CTRL_W)
    ) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    ({chan_sel, gain_sel, rate_fast}),
        .changed (ctrl_changed)
    );

    conv_seq_period_timer #(
        .SLOW_CYC (SLOW_CYC),
        .FAST_CYC (FAST_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (tmr_clear),
        .run        (tmr_run),
        .fast       (rate_fast),
        .period_end (period_end)
    );

    conv_seq_offset_unit #(
        .W (DATA_W)
    ) u_offset (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (store_off),
        .raw   (raw_word),
        .ovr   (raw_ovr),
        .word  (corr_word)
    );

    assign tmr_clear   = (state_q inside {SEQ_RESTART, SEQ_CAL_RESTART, SEQ_STANDBY});
    assign tmr_run     = (state_q inside {SEQ_RUN, SEQ_SETTLE, SEQ_CAL_SETTLE});
    assign settle_last = (settle_q == SET_LAST);
    assign cal_any     = cal_req || cal_pend_q;

    // Next-state decision: standby outranks a control change, which
    // outranks a calibration request, which outranks a period end.
    always_comb begin
        state_n   = state_q;
        emit      = 1'b0;
        store_off = 1'b0;
        take_cal  = 1'b0;
        unique case (state_q)
            SEQ_RUN: begin
                if (standby) begin
                    state_n = SEQ_STANDBY;
                end else if (ctrl_changed) begin
                    state_n = SEQ_RESTART;
                end else if (cal_any) begin
                    state_n  = SEQ_CAL_RESTART;
                    take_cal = 1'b1;
                end else if (period_end) begin
                    emit = 1'b1;
                    if (raw_ovr) begin
                        state_n = SEQ_RESTART;
                    end
                end
            end
            SEQ_RESTART: begin
                if (standby) begin
                    state_n = SEQ_STANDBY;
                end else if (!ctrl_changed) begin
                    state_n = SEQ_SETTLE;
                end
            end
            SEQ_SETTLE: begin
                if (standby) begin
                    state_n = SEQ_STANDBY;
                end else if (ctrl_changed) begin
                    state_n = SEQ_RESTART;
                end else if (cal_any) begin
                    state_n  = SEQ_CAL_RESTART;
                    take_cal = 1'b1;
                end else if (period_end && settle_last) begin
                    emit    = 1'b1;
                    state_n = raw_ovr ? SEQ_RESTART : SEQ_RUN;
                end
            end
            SEQ_CAL_RESTART: begin
                if (standby) begin
                    state_n = SEQ_STANDBY;
                end else if (!ctrl_changed) begin
                    state_n = SEQ_CAL_SETTLE;
                end
            end
            SEQ_CAL_SETTLE: begin
                if (standby) begin
                    state_n = SEQ_STANDBY;
                end else if (ctrl_changed) begin
                    state_n = SEQ_CAL_RESTART;
                end else if (period_end && settle_last) begin
                    store_off = 1'b1;
                    state_n   = SEQ_RESTART;
                end
            end
            SEQ_STANDBY: begin
                if (!standby) begin
                    state_n = SEQ_RESTART;
                end
            end
            default: begin
                state_n = SEQ_RESTART;
            end
        endcase
    end

    // State register together with its settling and pending-request companions.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= SEQ_RUN;
            settle_q   <= '0;
            cal_pend_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (take_cal) begin
                cal_pend_q <= 1'b0;
            end else if (cal_req) begin
                cal_pend_q <= 1'b1;
            end
            if (!(state_q inside {SEQ_SETTLE, SEQ_CAL_SETTLE})) begin
                settle_q <= '0;
            end else if (period_end && !settle_last) begin
                settle_q <= settle_q + 1'b1;
            end
        end
    end

    // Registered data outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o     <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= emit;
            if (emit) begin
                word_o <= corr_word;
            end
        end
    end

    // Control outputs follow the state directly.
    always_comb begin
        filt_rst = (state_q inside {SEQ_RESTART, SEQ_CAL_RESTART, SEQ_STANDBY});
        short_in = (state_q inside {SEQ_CAL_RESTART, SEQ_CAL_SETTLE});
    end

endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned CH_W   = 2,
    parameter int unsigned GAIN_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby,
    input logic [CH_W-1:0]   chan_sel,
    input logic [GAIN_W-1:0] gain_sel,
    input logic              rate_fast,
    input logic              raw_msb,
    input logic              raw_ovr,
    input logic [DATA_W-1:0] word_o,
    input logic              word_valid,
    input logic              filt_rst,
    input logic              short_in
);
    localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

    AST_CTRL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ({chan_sel, gain_sel, rate_fast} != $past({chan_sel, gain_sel, rate_fast})) |=> filt_rst); // R3

    AST_QUIET_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rst |=> !word_valid); // R4

    AST_CLIP_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(raw_ovr) && !$past(raw_msb)) |-> (word_o == POS_FS)); // R8

    AST_CLIP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(raw_ovr) && $past(raw_msb)) |-> (word_o == NEG_FS)); // R8

    AST_NO_WORD_SHORTED: assert property (@(posedge clk) disable iff (!rst_n)
        short_in |-> !word_valid); // R9

    AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> filt_rst); // R10

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R12

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_o)); // R12

endmodule

bind conv_sequencer conv_sequencer_chk #(
    .DATA_W (DATA_W),
    .CH_W   (CH_W),
    .GAIN_W (GAIN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby    (standby),
    .chan_sel   (chan_sel),
    .gain_sel   (gain_sel),
    .rate_fast  (rate_fast),
    .raw_msb    (raw_word[DATA_W-1]),
    .raw_ovr    (raw_ovr),
    .word_o     (word_o),
    .word_valid (word_valid),
    .filt_rst   (filt_rst),
    .short_in   (short_in)
);

// File: tb/conv_sequencer_tb.sv
module conv_sequencer_tb;
    localparam int NS = 40;
    localparam int NF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic [1:0]  chan_sel = 2'd0;
    logic [1:0]  gain_sel = 2'd0;
    logic        rate_fast = 1'b1;
    logic        cal_req = 1'b0;
    logic [23:0] raw_word = 24'h000123;
    logic        raw_ovr = 1'b0;
    logic [23:0] word_o;
    logic        word_valid;
    logic        filt_rst;
    logic        short_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic first_rst;
    logic first_short;

    always #5 clk = ~clk;

    conv_sequencer #(
        .DATA_W (24), .CH_W (2), .GAIN_W (2),
        .SLOW_CYC (NS), .FAST_CYC (NF), .SETTLE_PERIODS (4)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .standby (standby),
        .chan_sel (chan_sel), .gain_sel (gain_sel), .rate_fast (rate_fast),
        .cal_req (cal_req), .raw_word (raw_word), .raw_ovr (raw_ovr),
        .word_o (word_o), .word_valid (word_valid),
        .filt_rst (filt_rst), .short_in (short_in)
    );

    typedef struct packed {
        logic [23:0] raw;
        logic        ovr;
        logic [23:0] exp;
        logic [15:0] gap;
    } vec_t;

    // Stored offset is 0x000100 while this table runs.
    localparam vec_t VEC [0:6] = '{
        '{24'h000500, 1'b0, 24'h000400, 16'd10},   // R6
        '{24'h000000, 1'b0, 24'hFFFF00, 16'd10},   // R6
        '{24'h7FFFFF, 1'b0, 24'h7FFEFF, 16'd10},   // R6
        '{24'h800050, 1'b0, 24'h800000, 16'd10},   // R7
        '{24'h123456, 1'b1, 24'h7FFFFF, 16'd10},   // R8
        '{24'h900000, 1'b1, 24'h800000, 16'd41},   // R8
        '{24'hFFFFFF, 1'b0, 24'hFFFEFF, 16'd41}    // R8 gap, R6
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_valid(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                first_rst   = filt_rst;
                first_short = short_in;
                cal_req     = 1'b0;
            end
        end while (!word_valid && cyc < 2000);
        if (!word_valid) begin
            errors++;
            $display("FAIL timeout: no word_valid seen, actual 0 expected 1");
        end
    endtask

    initial begin
        int c;
        bit ok;
        // Reset state
        repeat (3) @(negedge clk);
        chk(word_valid == 0 && filt_rst == 0 && short_in == 0, "R1", "outputs in reset",
            {29'd0, word_valid, filt_rst, short_in}, 0);
        chk(word_o == 0, "R1", "word in reset", word_o, 0);
        rst_n = 1'b1;
        wait_valid(c);
        chk(c == NF, "R2", "first word edge", c, NF);
        chk(word_o == 24'h000123, "R6", "word with zero offset", word_o, 24'h000123);
        @(negedge clk);
        chk(!word_valid && word_o == 24'h000123, "R12", "strobe one cycle, word held",
            {word_valid, word_o}, {1'b0, 24'h000123});
        wait_valid(c);
        chk(c == NF - 1, "R2", "period spacing", c, NF - 1);

        // Rate change to slow
        rate_fast = 1'b0;
        wait_valid(c);
        chk(first_rst == 1'b1, "R3", "filter reset after rate change", first_rst, 1);
        chk(c == 4 * NS + 2, "R4", "settle slow", c, 4 * NS + 2);
        rate_fast = 1'b1;
        wait_valid(c);
        chk(c == 4 * NF + 2, "R4", "settle fast", c, 4 * NF + 2);

        // Second change during settling
        chan_sel = 2'd1;
        ok = 1'b1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (word_valid) ok = 1'b0;
        end
        chk(ok, "R5", "no word during settle", !ok, 0);
        gain_sel = 2'd2;
        wait_valid(c);
        chk(first_rst == 1'b1, "R3", "filter reset after gain change", first_rst, 1);
        chk(c == 4 * NF + 2, "R5", "settle restarted", c, 4 * NF + 2);

        // Calibration with offset 0x000100
        raw_word = 24'h000100;
        cal_req  = 1'b1;
        wait_valid(c);
        chk(first_short == 1'b1, "R9", "inputs shorted", first_short, 1);
        chk(c == 8 * NF + 3, "R9", "first word after cal", c, 8 * NF + 3);
        chk(short_in == 1'b0, "R9", "short released", short_in, 0);
        chk(word_o == 24'h000000, "R9", "offset removed", word_o, 0);

        // Vector table
        for (int k = 0; k < 7; k++) begin
            raw_word = VEC[k].raw;
            raw_ovr  = VEC[k].ovr;
            wait_valid(c);
            chk(word_o == VEC[k].exp, "R6/R7/R8", $sformatf("vector %0d word", k),
                word_o, VEC[k].exp);
            chk(c == int'(VEC[k].gap), "R8", $sformatf("vector %0d gap", k), c, VEC[k].gap);
        end
        raw_ovr = 1'b0;

        // Negative offset for the positive rail
        raw_word = 24'hFFFF00;
        cal_req  = 1'b1;
        wait_valid(c);
        chk(word_o == 24'h000000, "R9", "negative offset stored", word_o, 0);
        raw_word = 24'h7FFFF0;
        wait_valid(c);
        chk(word_o == 24'h7FFFFF, "R7", "positive saturation", word_o, 24'h7FFFFF);

        // Standby keeps the offset
        raw_word = 24'h000010;
        standby  = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (word_valid || !filt_rst) ok = 1'b0;
        end
        chk(ok, "R10", "parked in standby", !ok, 0);
        standby = 1'b0;
        wait_valid(c);
        chk(c == 4 * NF + 2, "R10", "restart after standby", c, 4 * NF + 2);
        chk(word_o == 24'h000110, "R10", "offset kept", word_o, 24'h000110);

        // Power-down clears the offset
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(word_valid == 0 && word_o == 0, "R1", "outputs in power-down",
            {word_valid, word_o}, 0);
        rst_n = 1'b1;
        wait_valid(c);
        chk(c == NF, "R2", "first word after power-down", c, NF);
        chk(word_o == 24'h000010, "R11", "offset cleared", word_o, 24'h000010);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule